// File: doc/BRIEF.md
# Programmable Baud Tick Divider

This block turns a fast reference clock into a one-cycle enable pulse at sixteen times the wanted serial bit rate. A 16-bit division factor is kept in two byte-wide holding registers, each loaded by its own write strobe from a shared 8-bit data bus. A down-counter divides the reference clock by that factor and raises the tick once per period. The current factor can be read back on a parallel output.

Whenever either byte is written, the counter restarts at once from the new full factor. It does not finish the count in progress. Software can therefore change the rate and know exactly when the next tick comes. For example, with a 3.6864 MHz reference, a factor of 12 gives ticks for 19200 baud and a factor of 6 gives ticks for 38400 baud. After reset, the block stays silent until a write leaves a nonzero factor in the registers. From then on, a factor of zero is handled as a factor of one, so the counter can never stall.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is 0 and `divisor` reads 0x0000.
- R2: A cycle with `wr_lo` high stores `wr_data` into `divisor[7:0]` at that clock edge, and `divisor[15:8]` keeps its value.
- R3: A cycle with `wr_hi` high stores `wr_data` into `divisor[15:8]` at that clock edge, and `divisor[7:0]` keeps its value.
- R4: Until some write leaves a nonzero 16-bit factor, `tick` stays 0, including after writes of zero.
- R5: With a factor D of 2 or more and no writes, `tick` is high for exactly one cycle in every D cycles (D=12 and D=6 are among the tested factors).
- R6: A write to either byte restarts the count. If the write is taken at edge k, `tick` is 0 after edge k and is first high after edge k+D, where D is the new full factor. This holds wherever the old count stood.
- R7: With a factor of 1, `tick` is high after every clock edge that follows the write.
- R8: Once running, a factor of 0 gives the same tick pattern as a factor of 1, while `divisor` still reads 0x0000.
- R9: With a factor of 2 or more, `tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for the low byte of the factor |
| wr_hi | input | 1 | Write strobe for the high byte of the factor |
| wr_data | input | 8 | Byte written by either strobe |
| tick | output | 1 | Registered one-cycle pulse at the divided rate |
| divisor | output | 16 | Current 16-bit division factor |

## Verification
The assertions assume that reset is applied synchronously before the strobes are used. They also assume that `wr_data` is valid in every cycle where a strobe is high. The stimulus raises at most one strobe per cycle, so each byte update and each restart can be traced to a single edge. All strobes and data are driven on the falling edge, held across exactly one rising edge, and then dropped. The bench samples `tick` one nanosecond after each rising edge, so it counts cycles from the write edge named in R6.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  localparam int BYTE_W_DEF    = 8;
  localparam int NUM_BYTES_DEF = 2;

  // per-cycle decision taken by the down-counter
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,   // not running yet: stay quiet
    ACT_LOAD = 2'd1,   // byte written: restart from the new factor
    ACT_STEP = 2'd2,   // count down by one
    ACT_WRAP = 2'd3    // period done: emit tick and reload
  } cnt_act_e;

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BYTES-1:0] wr_en,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [DIV_W-1:0]     div_q,
  output logic [DIV_W-1:0]     div_next,
  output logic                 wr_any
);

  assign wr_any = |wr_en;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    assign byte_d = wr_en[b] ? wr_data : byte_q;

    always_ff @(posedge clk) begin
      if (rst) byte_q <= '0;
      else     byte_q <= byte_d;
    end

    assign div_q[b*BYTE_W +: BYTE_W]    = byte_q;
    assign div_next[b*BYTE_W +: BYTE_W] = byte_d;

    // R2 (low byte) and R3 (high byte): an unwritten byte keeps its value
    p_byte_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !wr_en[b] |=> $stable(div_q[b*BYTE_W +: BYTE_W]));

    // R2 / R3: a written byte takes the bus value
    p_byte_take_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en[b] |=> div_q[b*BYTE_W +: BYTE_W] == $past(wr_data));
  end

endmodule

// File: rtl/baud_div_arm.sv
module baud_div_arm #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_any,
  input  logic [DIV_W-1:0] div_next,
  output logic             run
);

  always_ff @(posedge clk) begin
    if (rst)                            run <= 1'b0;
    else if (wr_any && (div_next != '0)) run <= 1'b1;
  end

  // R4: once armed the divider stays armed until reset
  p_run_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    run |=> run);

  // R4: arming only follows a write
  p_run_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(wr_any));

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
  import baud_div_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_next,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_cur;
  logic [DIV_W-1:0] eff_load;
  cnt_act_e         act;

  // a zero factor behaves as one
  assign eff_cur  = (div_q    == '0) ? ONE : div_q;
  assign eff_load = (div_next == '0) ? ONE : div_next;

  always_comb begin
    if (load)              act = ACT_LOAD;
    else if (!run)         act = ACT_HOLD;
    else if (cnt_q <= ONE) act = ACT_WRAP;
    else                   act = ACT_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin cnt_q <= eff_load;    tick <= 1'b0; end
        ACT_HOLD: begin cnt_q <= '0;          tick <= 1'b0; end
        ACT_WRAP: begin cnt_q <= eff_cur;     tick <= 1'b1; end
        default:  begin cnt_q <= cnt_q - ONE; tick <= 1'b0; end
      endcase
    end
  end

  // R4: no tick before the divider is armed
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  // R6: a write restarts the count from the stored factor with no tick
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick && (cnt_q == ((div_q == '0) ? ONE : div_q)));

  // R5: while running the count stays inside 1..factor
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q != '0) && (cnt_q <= eff_cur));

  // R7 / R8: factor of one (or zero) ticks every cycle
  p_unit_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (run && !load && (div_q <= ONE)) |=> tick);

  // R9: tick is a single-cycle pulse for factors of two or more
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && (div_q > ONE)) |=> !tick);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_div_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF,
  localparam int NUM_BYTES = NUM_BYTES_DEF,
  localparam int DIV_W     = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic [DIV_W-1:0]  divisor
);

  logic [NUM_BYTES-1:0] wr_en;
  logic [DIV_W-1:0]     div_q;
  logic [DIV_W-1:0]     div_next;
  logic                 wr_any;
  logic                 run;

  assign wr_en   = {wr_hi, wr_lo};
  assign divisor = div_q;

  baud_div_latch #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) i_latch (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .div_q    (div_q),
    .div_next (div_next),
    .wr_any   (wr_any)
  );

  baud_div_arm #(
    .DIV_W (DIV_W)
  ) i_arm (
    .clk      (clk),
    .rst      (rst),
    .wr_any   (wr_any),
    .div_next (div_next),
    .run      (run)
  );

  baud_div_counter #(
    .DIV_W (DIV_W)
  ) i_counter (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .load     (wr_any),
    .div_q    (div_q),
    .div_next (div_next),
    .tick     (tick)
  );

  // R1: reset clears tick and the readback
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> !tick && (divisor == '0));

  // R8: a zero factor while running still ticks
  p_zero_as_one_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_any && (divisor == '0)) |=> tick);

endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_lo = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        tick;
  logic [15:0] divisor;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .tick    (tick),
    .divisor (divisor)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // write one byte; returns 1 ns after the taking edge
  task automatic write_byte(input bit hi, input logic [7:0] val);
    @(negedge clk);
    wr_data = val;
    wr_lo   = !hi;
    wr_hi   = hi;
    @(posedge clk);
    #1;
    wr_lo   = 1'b0;
    wr_hi   = 1'b0;
  endtask

  // after a write edge: tick high exactly after edges k+D, k+2D, ...
  task automatic expect_ticks(input int d, input int n, input string req);
    for (int j = 1; j <= n; j++) begin
      @(posedge clk);
      #1;
      check(tick == ((j % d) == 0), req, tick, ((j % d) == 0));
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      #1;
      check(tick == 1'b0, req, tick, 0);
    end
  endtask

  task automatic t_reset;   // R1
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check(tick == 1'b0, "R1 tick", tick, 0);
    check(divisor == 16'h0000, "R1 divisor", divisor, 0);
  endtask

  task automatic t_idle_zero;   // R4
    write_byte(1'b0, 8'h00);
    write_byte(1'b1, 8'h00);
    check(divisor == 16'h0000, "R4 divisor", divisor, 0);
    expect_quiet(40, "R4 quiet");
  endtask

  task automatic t_div12;   // R2 R5 R9
    write_byte(1'b0, 8'd12);
    check(divisor == 16'd12, "R2 low byte", divisor, 12);
    expect_ticks(12, 60, "R5 R9 period 12");
  endtask

  task automatic t_high_byte;   // R3 R5
    write_byte(1'b1, 8'h01);
    check(divisor == 16'h010C, "R3 high byte", divisor, 16'h010C);
    expect_ticks(268, 540, "R5 period 268");
  endtask

  task automatic t_restart;   // R2 R3 R5 R6
    write_byte(1'b0, 8'd6);
    check(divisor == 16'h0106, "R2 low keeps high", divisor, 16'h0106);
    write_byte(1'b1, 8'd0);
    check(divisor == 16'd6, "R3 high keeps low", divisor, 6);
    expect_ticks(6, 21, "R5 R6 period 6");
    write_byte(1'b0, 8'd10);
    check(divisor == 16'd10, "R6 divisor", divisor, 10);
    expect_ticks(10, 30, "R6 restart 10");
  endtask

  task automatic t_unit;   // R7
    write_byte(1'b0, 8'd1);
    check(divisor == 16'd1, "R7 divisor", divisor, 1);
    expect_ticks(1, 10, "R7 every cycle");
  endtask

  task automatic t_zero_run;   // R8
    write_byte(1'b0, 8'd0);
    check(divisor == 16'd0, "R8 divisor", divisor, 0);
    expect_ticks(1, 10, "R8 zero as one");
  endtask

  task automatic t_div2;   // R5 R9
    write_byte(1'b0, 8'd2);
    expect_ticks(2, 12, "R9 period 2");
  endtask

  initial begin
    t_reset();
    t_idle_zero();
    t_div12();
    t_high_byte();
    t_restart();
    t_unit();
    t_zero_run();
    t_div2();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule